// File: doc/BRIEF.md
# Address-Space-Tagged Virtual Read Cache

A direct-mapped read cache that is both indexed and tagged with the virtual address. Each line also records the address-space identifier (ASID) that was in force when the line was filled. Because of this, lines that belong to different processes can stay in the cache together, and a context switch needs no flush. Software writes the current ASID into a register inside the block. Every lookup compares the stored ASID against the ASID that was current when the lookup was accepted. One reserved ASID value (all ones, 0xFF by default) marks a line as shared, and a shared line hits whatever ASID is current.

A hit returns the stored word one cycle after the request is accepted, without waiting for address translation. Every accepted lookup still sends a translation request on a separate request/response port in its first cycle, so that the physical address is already on its way if the lookup misses. On a miss the block waits for that translation response and issues one read at the physical address on a simple memory port. When the data comes back, the block returns it and writes the data, the virtual tag, the lookup's ASID and the valid bit into the line in the same cycle. Translation responses come back in request order. Responses that belong to lookups which hit are counted and thrown away.

A whole-cache invalidate command walks the lines one per cycle and clears every valid bit. While the walk runs, a busy flag is high and new lookups are refused. Software can use this as the costly but always-correct fallback of flushing on every switch.

Top module: `asid_vcache`

## Requirements
- R1: A lookup hits when the indexed line is valid, its stored virtual tag equals the request's tag bits (vaddr[31:6] at defaults), and its stored ASID equals the lookup's ASID. A hit raises resp_valid in the cycle after acceptance with the stored word and makes no memory request.
- R2: A valid line whose stored ASID differs from the lookup's ASID, and is not the shared value 0xFF, misses. The fill then replaces that line.
- R3: A line filled while the current ASID is 0xFF hits for every current ASID.
- R4: On a miss the block waits for the translation response and issues exactly one memory read at the returned physical address. It returns the memory word on resp_valid. The line is filled with the ASID that was current when the lookup was accepted, so a later ASID write during the miss does not change the fill.
- R5: Every accepted lookup, hit or miss, drives xlat_req_valid for one cycle in the cycle after acceptance, carrying the request's virtual address.
- R6: Translation responses that belong to lookups which hit are discarded. A miss that follows directly after a hit is refilled from its own translation, not from the hit's stale one.
- R7: Writing the ASID register leaves every line intact. Lines filled under two ASIDs at different indices both hit again after switching back to each ASID.
- R8: An inv_start pulse accepted while idle holds busy high for exactly LINES cycles (16 at defaults), starting at the next cycle. req_ready is low during that time, and afterwards every earlier line, shared lines included, misses.
- R9: After reset every line is invalid, req_ready is 1, and busy, resp_valid, xlat_req_valid and mem_req_valid are 0.
- R10: The line index is vaddr[5:2] at defaults. A request with the same index and a different tag misses and evicts the older line, which then misses in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| asid_wr | input | 1 | Write strobe for the current-ASID register |
| asid_wdata | input | 8 | New current ASID |
| inv_start | input | 1 | Start a whole-cache invalidate |
| busy | output | 1 | Invalidate pending or walking |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| req_vaddr | input | 32 | Virtual byte address of the lookup |
| resp_valid | output | 1 | Read data valid (one cycle) |
| resp_data | output | 32 | Read data |
| xlat_req_valid | output | 1 | Translation request (one cycle) |
| xlat_req_vaddr | output | 32 | Virtual address to translate |
| xlat_rsp_valid | input | 1 | Translation response valid, in request order |
| xlat_rsp_paddr | input | 32 | Translated physical address |
| mem_req_valid | output | 1 | Refill read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Physical refill address |
| mem_rsp_valid | input | 1 | Refill data valid |
| mem_rsp_data | input | 32 | Refill data |

## Verification
The hardest situation to reach from the ports is a stale translation response arriving while a later miss is waiting for its own. The stimulus builds it by sending a lookup that hits and, as soon as req_ready returns, a lookup that misses. The bench translator has a three-cycle latency, so the hit's response lands during the miss's wait. Its physical address, and the memory data derived from it, depend on both ASID and address, so refilling from the wrong response shows up in the returned word. The second hard case is an ASID write issued in the middle of a miss, which is placed a few cycles after acceptance. The bench then checks that the line answers to the old ASID.

// File: rtl/asid_vcache_pkg.sv
`timescale 1ns/1ps
package asid_vcache_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_LOOK  = 3'd1,
      ST_WXL   = 3'd2,
      ST_MREQ  = 3'd3,
      ST_MWAIT = 3'd4,
      ST_INV   = 3'd5
   } vc_state_t;
endpackage

// File: rtl/asid_vcache_store.sv
`timescale 1ns/1ps
module asid_vcache_store #(
   parameter int LINES  = 16,
   parameter int TAG_W  = 26,
   parameter int ASID_W = 8,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [ASID_W-1:0] rd_asid,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              clr_en,
   input  logic [IDX_W-1:0]  clr_idx
);
   logic [LINES-1:0]             valid_v;
   logic [LINES-1:0][TAG_W-1:0]  tag_v;
   logic [LINES-1:0][ASID_W-1:0] asid_v;
   logic [LINES-1:0][DATA_W-1:0] data_v;

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic              valid_q;
      logic [TAG_W-1:0]  tag_q;
      logic [ASID_W-1:0] asid_q;
      logic [DATA_W-1:0] data_q;
      logic              sel_wr;
      logic              sel_clr;

      assign sel_wr  = wr_en  && (wr_idx  == IDX_W'(g));
      assign sel_clr = clr_en && (clr_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q <= 1'b0;
         end else if (sel_clr) begin
            valid_q <= 1'b0;
         end else if (sel_wr) begin
            valid_q <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (sel_wr) begin
            tag_q  <= wr_tag;
            asid_q <= wr_asid;
            data_q <= wr_data;
         end
      end

      assign valid_v[g] = valid_q;
      assign tag_v[g]   = tag_q;
      assign asid_v[g]  = asid_q;
      assign data_v[g]  = data_q;
   end

   assign rd_valid = valid_v[rd_idx];
   assign rd_tag   = tag_v[rd_idx];
   assign rd_asid  = asid_v[rd_idx];
   assign rd_data  = data_v[rd_idx];
endmodule

// File: rtl/asid_vcache_match.sv
`timescale 1ns/1ps
module asid_vcache_match #(
   parameter int TAG_W       = 26,
   parameter int ASID_W      = 8,
   parameter int SHARED_ASID = 255,
   parameter bit SHARED_EN   = 1'b1
) (
   input  logic              line_valid,
   input  logic [TAG_W-1:0]  line_tag,
   input  logic [ASID_W-1:0] line_asid,
   input  logic [TAG_W-1:0]  look_tag,
   input  logic [ASID_W-1:0] look_asid,
   output logic              hit
);
   logic tag_ok;
   logic asid_ok;

   assign tag_ok = (line_tag == look_tag);

   if (SHARED_EN) begin : g_shared
      assign asid_ok = (line_asid == look_asid) ||
                       (line_asid == ASID_W'(SHARED_ASID));
   end else begin : g_private
      assign asid_ok = (line_asid == look_asid);
   end

   assign hit = line_valid && tag_ok && asid_ok;
endmodule

// File: rtl/asid_vcache_ctrl.sv
`timescale 1ns/1ps
module asid_vcache_ctrl
   import asid_vcache_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int PA_W   = 32,
   parameter int DATA_W = 32,
   parameter int LINES  = 16,
   parameter int ASID_W = 8,
   parameter int DROP_W = 2,
   localparam int IDX_W    = $clog2(LINES),
   localparam int OFF_W    = $clog2(DATA_W / 8),
   localparam int TAG_W    = VA_W - IDX_W - OFF_W,
   localparam int DROP_MAX = (1 << DROP_W) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ASID_W-1:0] cur_asid,
   input  logic              inv_start,
   output logic              busy,
   output logic              inv_walk,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_vaddr,
   output logic              resp_valid,
   output logic [DATA_W-1:0] resp_data,
   output logic              xlat_req_valid,
   output logic [VA_W-1:0]   xlat_req_vaddr,
   input  logic              xlat_rsp_valid,
   input  logic [PA_W-1:0]   xlat_rsp_paddr,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [PA_W-1:0]   mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data,
   input  logic              look_hit,
   input  logic [DATA_W-1:0] look_data,
   output logic [IDX_W-1:0]  look_idx,
   output logic [TAG_W-1:0]  look_tag,
   output logic [ASID_W-1:0] look_asid,
   output logic              fill_en,
   output logic              clr_en,
   output logic [IDX_W-1:0]  clr_idx
);
   vc_state_t         st_q;
   logic [VA_W-1:0]   vaddr_q;
   logic [ASID_W-1:0] asid_q;
   logic [PA_W-1:0]   paddr_q;
   logic [IDX_W-1:0]  walk_q;
   logic [DROP_W-1:0] drop_q;
   logic              inv_pend_q;
   logic              accept;
   logic              drop_inc;
   logic              drop_dec;

   assign req_ready = (st_q == ST_IDLE) && !inv_pend_q && !inv_start &&
                      (drop_q != DROP_W'(DROP_MAX));
   assign accept    = req_valid && req_ready;
   assign drop_inc  = (st_q == ST_LOOK) && look_hit;
   assign drop_dec  = xlat_rsp_valid && (drop_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         vaddr_q    <= '0;
         asid_q     <= '0;
         paddr_q    <= '0;
         walk_q     <= '0;
         drop_q     <= '0;
         inv_pend_q <= 1'b0;
      end else begin
         inv_pend_q <= (st_q == ST_IDLE) ? 1'b0 : (inv_pend_q | inv_start);
         case ({drop_inc, drop_dec})
            2'b10:   drop_q <= drop_q + 1'b1;
            2'b01:   drop_q <= drop_q - 1'b1;
            default: drop_q <= drop_q;
         endcase
         case (st_q)
            ST_IDLE: begin
               if (inv_start || inv_pend_q) begin
                  st_q   <= ST_INV;
                  walk_q <= '0;
               end else if (accept) begin
                  st_q    <= ST_LOOK;
                  vaddr_q <= req_vaddr;
                  asid_q  <= cur_asid;
               end
            end
            ST_LOOK:  st_q <= look_hit ? ST_IDLE : ST_WXL;
            ST_WXL: begin
               if (xlat_rsp_valid && (drop_q == '0)) begin
                  paddr_q <= xlat_rsp_paddr;
                  st_q    <= ST_MREQ;
               end
            end
            ST_MREQ:  if (mem_req_ready) st_q <= ST_MWAIT;
            ST_MWAIT: if (mem_rsp_valid) st_q <= ST_IDLE;
            ST_INV: begin
               walk_q <= walk_q + 1'b1;
               if (walk_q == IDX_W'(LINES - 1)) st_q <= ST_IDLE;
            end
            default:  st_q <= ST_IDLE;
         endcase
      end
   end

   assign look_idx       = vaddr_q[OFF_W +: IDX_W];
   assign look_tag       = vaddr_q[VA_W-1 -: TAG_W];
   assign look_asid      = asid_q;
   assign xlat_req_valid = (st_q == ST_LOOK);
   assign xlat_req_vaddr = vaddr_q;
   assign mem_req_valid  = (st_q == ST_MREQ);
   assign mem_req_addr   = paddr_q;
   assign fill_en        = (st_q == ST_MWAIT) && mem_rsp_valid;
   assign resp_valid     = drop_inc || fill_en;
   assign resp_data      = fill_en ? mem_rsp_data : look_data;
   assign clr_en         = (st_q == ST_INV);
   assign clr_idx        = walk_q;
   assign inv_walk       = (st_q == ST_INV);
   assign busy           = (st_q == ST_INV) || inv_pend_q;
endmodule

// File: rtl/asid_vcache.sv
`timescale 1ns/1ps
module asid_vcache #(
   parameter int VA_W        = 32,
   parameter int PA_W        = 32,
   parameter int DATA_W      = 32,
   parameter int LINES       = 16,
   parameter int ASID_W      = 8,
   parameter int SHARED_ASID = 255,
   parameter bit SHARED_EN   = 1'b1,
   parameter int DROP_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              asid_wr,
   input  logic [ASID_W-1:0] asid_wdata,
   input  logic              inv_start,
   output logic              busy,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_vaddr,
   output logic              resp_valid,
   output logic [DATA_W-1:0] resp_data,
   output logic              xlat_req_valid,
   output logic [VA_W-1:0]   xlat_req_vaddr,
   input  logic              xlat_rsp_valid,
   input  logic [PA_W-1:0]   xlat_rsp_paddr,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [PA_W-1:0]   mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data
);
   localparam int IDX_W = $clog2(LINES);
   localparam int OFF_W = $clog2(DATA_W / 8);
   localparam int TAG_W = VA_W - IDX_W - OFF_W;

   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("asid_vcache: LINES must be a power of two of at least 2");
   end
   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
      $error("asid_vcache: DATA_W must be a power-of-two number of bytes");
   end
   if (SHARED_ASID < 0 || SHARED_ASID >= (1 << ASID_W)) begin : g_bad_shared
      $error("asid_vcache: SHARED_ASID does not fit in ASID_W bits");
   end
   if (TAG_W < 1 || DROP_W < 1) begin : g_bad_misc
      $error("asid_vcache: address too narrow or DROP_W zero");
   end

   logic [ASID_W-1:0] cur_asid_q;
   logic              inv_walk;
   logic              look_hit;
   logic [IDX_W-1:0]  look_idx;
   logic [TAG_W-1:0]  look_tag;
   logic [ASID_W-1:0] look_asid;
   logic              fill_en;
   logic              clr_en;
   logic [IDX_W-1:0]  clr_idx;
   logic              line_valid;
   logic [TAG_W-1:0]  line_tag;
   logic [ASID_W-1:0] line_asid;
   logic [DATA_W-1:0] line_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_asid_q <= '0;
      else if (asid_wr) cur_asid_q <= asid_wdata;
   end

   asid_vcache_ctrl #(
      .VA_W(VA_W), .PA_W(PA_W), .DATA_W(DATA_W), .LINES(LINES),
      .ASID_W(ASID_W), .DROP_W(DROP_W)
   ) ctrl_i (
      .clk(clk), .rst_n(rst_n), .cur_asid(cur_asid_q),
      .inv_start(inv_start), .busy(busy), .inv_walk(inv_walk),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .resp_valid(resp_valid), .resp_data(resp_data),
      .xlat_req_valid(xlat_req_valid), .xlat_req_vaddr(xlat_req_vaddr),
      .xlat_rsp_valid(xlat_rsp_valid), .xlat_rsp_paddr(xlat_rsp_paddr),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .look_hit(look_hit), .look_data(line_data),
      .look_idx(look_idx), .look_tag(look_tag), .look_asid(look_asid),
      .fill_en(fill_en), .clr_en(clr_en), .clr_idx(clr_idx)
   );

   asid_vcache_store #(
      .LINES(LINES), .TAG_W(TAG_W), .ASID_W(ASID_W), .DATA_W(DATA_W)
   ) store_i (
      .clk(clk), .rst_n(rst_n), .rd_idx(look_idx),
      .rd_valid(line_valid), .rd_tag(line_tag), .rd_asid(line_asid),
      .rd_data(line_data), .wr_en(fill_en), .wr_idx(look_idx),
      .wr_tag(look_tag), .wr_asid(look_asid), .wr_data(mem_rsp_data),
      .clr_en(clr_en), .clr_idx(clr_idx)
   );

   asid_vcache_match #(
      .TAG_W(TAG_W), .ASID_W(ASID_W), .SHARED_ASID(SHARED_ASID),
      .SHARED_EN(SHARED_EN)
   ) match_i (
      .line_valid(line_valid), .line_tag(line_tag), .line_asid(line_asid),
      .look_tag(look_tag), .look_asid(look_asid), .hit(look_hit)
   );
endmodule

// File: rtl/asid_vcache_chk.sv
`timescale 1ns/1ps
module asid_vcache_chk #(
   parameter int LINES = 16,
   parameter int PA_W  = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic            busy,
   input logic            inv_walk,
   input logic            resp_valid,
   input logic            xlat_req_valid,
   input logic            xlat_rsp_valid,
   input logic            mem_req_valid,
   input logic            mem_req_ready,
   input logic [PA_W-1:0] mem_req_addr
);
   localparam int CW = $clog2(LINES) + 2;
   logic [CW-1:0] walk_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) walk_cnt <= '0;
      else if (inv_walk) walk_cnt <= walk_cnt + 1'b1;
      else walk_cnt <= '0;
   end

   // R8: lookups are refused while invalidate is pending or walking
   p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !req_ready);

   // R8: the walk never lasts beyond LINES cycles
   p_walk_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
      inv_walk |-> (walk_cnt < CW'(LINES)));

   // R5: accepted lookup sends a translation request next cycle
   p_xlat_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> xlat_req_valid);

   // R4: a refill read starts only right after a translation response
   p_mem_after_xlat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req_valid) |-> $past(xlat_rsp_valid));

   // R4: a waiting refill request holds its address
   p_mem_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R1: each response is a single-cycle pulse
   p_resp_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid);

   // R1: no response and refill request in the same cycle
   p_resp_no_mem_r1: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> !mem_req_valid);
endmodule

bind asid_vcache asid_vcache_chk #(.LINES(LINES), .PA_W(PA_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .busy(busy), .inv_walk(inv_walk), .resp_valid(resp_valid),
   .xlat_req_valid(xlat_req_valid), .xlat_rsp_valid(xlat_rsp_valid),
   .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
   .mem_req_addr(mem_req_addr)
);

// File: tb/asid_vcache_tb_top.sv
`timescale 1ns/1ps
module asid_vcache_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        asid_wr = 1'b0;
   logic [7:0]  asid_wdata = '0;
   logic        inv_start = 1'b0;
   logic        busy;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic        resp_valid;
   logic [31:0] resp_data;
   logic        xlat_req_valid;
   logic [31:0] xlat_req_vaddr;
   logic        xlat_rsp_valid;
   logic [31:0] xlat_rsp_paddr;
   logic        mem_req_valid;
   logic        mem_req_ready;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_data;

   int   total = 0;
   int   bad = 0;
   int   mem_cnt = 0;
   int   xlat_cnt = 0;
   logic [31:0] last_mem_addr = '0;
   logic [7:0]  tb_asid = '0;
   bit   done = 1'b0;

   always #10 clk = ~clk;

   asid_vcache dut_i (
      .clk(clk), .rst_n(rst_n), .asid_wr(asid_wr), .asid_wdata(asid_wdata),
      .inv_start(inv_start), .busy(busy), .req_valid(req_valid),
      .req_ready(req_ready), .req_vaddr(req_vaddr), .resp_valid(resp_valid),
      .resp_data(resp_data), .xlat_req_valid(xlat_req_valid),
      .xlat_req_vaddr(xlat_req_vaddr), .xlat_rsp_valid(xlat_rsp_valid),
      .xlat_rsp_paddr(xlat_rsp_paddr), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
   );

   function automatic logic [31:0] trans(input logic [7:0] a, input logic [31:0] va);
      return {a, va[23:0]};
   endfunction
   function automatic logic [31:0] memval(input logic [31:0] pa);
      return pa ^ 32'h5A5A_5A5A;
   endfunction

   // translator model: three-cycle in-order pipeline
   logic [32:0] xp0 = '0, xp1 = '0, xp2 = '0;
   always @(posedge clk) begin
      xp0 <= {xlat_req_valid, trans(tb_asid, xlat_req_vaddr)};
      xp1 <= xp0;
      xp2 <= xp1;
      if (xlat_req_valid) xlat_cnt <= xlat_cnt + 1;
   end
   assign xlat_rsp_valid = xp2[32];
   assign xlat_rsp_paddr = xp2[31:0];

   // memory model: always ready, two-cycle read
   logic [32:0] mp0 = '0, mp1 = '0;
   assign mem_req_ready = 1'b1;
   always @(posedge clk) begin
      mp0 <= {mem_req_valid, memval(mem_req_addr)};
      mp1 <= mp0;
      if (mem_req_valid) begin
         mem_cnt <= mem_cnt + 1;
         last_mem_addr <= mem_req_addr;
      end
   end
   assign mem_rsp_valid = mp1[32];
   assign mem_rsp_data  = mp1[31:0];

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic set_asid(input logic [7:0] a);
      @(negedge clk);
      asid_wr = 1'b1; asid_wdata = a; tb_asid = a;
      @(negedge clk);
      asid_wr = 1'b0;
   endtask

   task automatic do_read(input logic [31:0] va, output logic [31:0] data,
                          output int lat, output bit missed);
      int m0;
      int guard;
      guard = 0;
      while (!req_ready && guard < 200) begin @(negedge clk); guard++; end
      m0 = mem_cnt;
      req_valid = 1'b1; req_vaddr = va;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!resp_valid && lat < 100) begin @(negedge clk); lat++; end
      data = resp_data;
      missed = (mem_cnt != m0);
   endtask

   localparam logic [31:0] VA_A  = 32'h0000_1010;
   localparam logic [31:0] VA_A2 = 32'h0000_5010;
   localparam logic [31:0] VA_B  = 32'h0000_2024;
   localparam logic [31:0] VA_C  = 32'h0000_3038;
   localparam logic [31:0] VA_S  = 32'h0000_0040;

   task automatic t_reset;
      check(req_ready == 1'b1, "R9 req_ready", {31'b0, req_ready}, 32'd1);
      check(busy == 1'b0, "R9 busy", {31'b0, busy}, 32'd0);
      check(resp_valid == 1'b0, "R9 resp_valid", {31'b0, resp_valid}, 32'd0);
      check(xlat_req_valid == 1'b0 && mem_req_valid == 1'b0, "R9 requests idle",
            {30'b0, xlat_req_valid, mem_req_valid}, 32'd0);
   endtask

   task automatic t_fill_hit;
      logic [31:0] d; int lat; bit m; int x0;
      set_asid(8'h01);
      x0 = xlat_cnt;
      do_read(VA_A, d, lat, m);
      check(m, "R4 first read misses", {31'b0, m}, 32'd1);
      check(d == memval(trans(8'h01, VA_A)), "R4 fill data", d, memval(trans(8'h01, VA_A)));
      check(last_mem_addr == trans(8'h01, VA_A), "R4 refill address",
            last_mem_addr, trans(8'h01, VA_A));
      x0 = xlat_cnt;
      do_read(VA_A, d, lat, m);
      check(!m && lat == 1, "R1 hit latency and no refill", lat, 32'd1);
      check(d == memval(trans(8'h01, VA_A)), "R1 hit data", d, memval(trans(8'h01, VA_A)));
      @(negedge clk);
      check(xlat_cnt == x0 + 1, "R5 translation sent on hit", xlat_cnt, x0 + 1);
   endtask

   task automatic t_isolate;
      logic [31:0] d; int lat; bit m;
      set_asid(8'h02);
      do_read(VA_A, d, lat, m);
      check(m, "R2 other ASID misses", {31'b0, m}, 32'd1);
      check(d == memval(trans(8'h02, VA_A)), "R2 refill data", d, memval(trans(8'h02, VA_A)));
      set_asid(8'h01);
      do_read(VA_A, d, lat, m);
      check(m, "R2 replaced line misses for old ASID", {31'b0, m}, 32'd1);
   endtask

   task automatic t_coexist;
      logic [31:0] d; int lat; bit m;
      do_read(VA_B, d, lat, m);
      set_asid(8'h02);
      do_read(VA_C, d, lat, m);
      set_asid(8'h01);
      do_read(VA_B, d, lat, m);
      check(!m && d == memval(trans(8'h01, VA_B)), "R7 ASID 1 line kept", d,
            memval(trans(8'h01, VA_B)));
      set_asid(8'h02);
      do_read(VA_C, d, lat, m);
      check(!m && d == memval(trans(8'h02, VA_C)), "R7 ASID 2 line kept", d,
            memval(trans(8'h02, VA_C)));
   endtask

   task automatic t_shared;
      logic [31:0] d; int lat; bit m;
      set_asid(8'hFF);
      do_read(VA_S, d, lat, m);
      set_asid(8'h03);
      do_read(VA_S, d, lat, m);
      check(!m && d == memval(trans(8'hFF, VA_S)), "R3 shared hit ASID 3", d,
            memval(trans(8'hFF, VA_S)));
      set_asid(8'h07);
      do_read(VA_S, d, lat, m);
      check(!m && lat == 1, "R3 shared hit ASID 7", {31'b0, m}, 32'd0);
   endtask

   task automatic t_conflict;
      logic [31:0] d; int lat; bit m;
      set_asid(8'h01);
      do_read(VA_A, d, lat, m);
      check(!m, "R10 line present before conflict", {31'b0, m}, 32'd0);
      do_read(VA_A2, d, lat, m);
      check(m && d == memval(trans(8'h01, VA_A2)), "R10 same index other tag misses", d,
            memval(trans(8'h01, VA_A2)));
      do_read(VA_A, d, lat, m);
      check(m, "R10 evicted line misses", {31'b0, m}, 32'd1);
   endtask

   task automatic t_latched;
      logic [31:0] d; int lat; bit m; int guard;
      set_asid(8'h04);
      guard = 0;
      while (!req_ready && guard < 200) begin @(negedge clk); guard++; end
      req_valid = 1'b1; req_vaddr = VA_C;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      asid_wr = 1'b1; asid_wdata = 8'h05; tb_asid = 8'h05;
      @(negedge clk);
      asid_wr = 1'b0;
      guard = 0;
      while (!resp_valid && guard < 100) begin @(negedge clk); guard++; end
      check(resp_data == memval(trans(8'h04, VA_C)), "R4 miss data under old ASID",
            resp_data, memval(trans(8'h04, VA_C)));
      set_asid(8'h04);
      do_read(VA_C, d, lat, m);
      check(!m && lat == 1, "R4 line tagged with accept-time ASID", {31'b0, m}, 32'd0);
   endtask

   task automatic t_stale;
      logic [31:0] d; int lat; bit m;
      do_read(VA_C, d, lat, m);
      check(!m, "R6 hit before miss", {31'b0, m}, 32'd0);
      do_read(VA_B, d, lat, m);
      check(m && last_mem_addr == trans(8'h04, VA_B), "R6 refill uses own translation",
            last_mem_addr, trans(8'h04, VA_B));
      check(d == memval(trans(8'h04, VA_B)), "R6 miss data after hit", d,
            memval(trans(8'h04, VA_B)));
   endtask

   task automatic t_invalidate;
      logic [31:0] d; int lat; bit m; int nbusy; bit rdy_seen;
      nbusy = 0; rdy_seen = 1'b0;
      @(negedge clk);
      inv_start = 1'b1;
      @(negedge clk);
      inv_start = 1'b0;
      for (int i = 0; i < 40; i++) begin
         if (busy) begin
            nbusy++;
            if (req_ready) rdy_seen = 1'b1;
         end
         @(negedge clk);
      end
      check(nbusy == 16, "R8 busy length", nbusy, 32'd16);
      check(!rdy_seen, "R8 ready low while busy", {31'b0, rdy_seen}, 32'd0);
      do_read(VA_C, d, lat, m);
      check(m, "R8 line gone after invalidate", {31'b0, m}, 32'd1);
      set_asid(8'h03);
      do_read(VA_S, d, lat, m);
      check(m, "R8 shared line gone after invalidate", {31'b0, m}, 32'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_fill_hit;
      t_isolate;
      t_coexist;
      t_shared;
      t_conflict;
      t_latched;
      t_stale;
      t_invalidate;
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule